// File: doc/BRIEF.md
# Prioritized Sixteen-Level Interrupt Controller

This block gathers sixteen interrupt request lines, records each request in a pending register, and picks one request to service. Each line is sampled either on its rising edge or as a level, depending on the source. A mask register and a global enable limit which pending requests may be taken. A few sources are exempt from one or both of these controls. Among the requests that may be taken, the lowest-numbered source wins.

When a request is accepted, the block copies the processor's current instruction counter into a save register and clears the global enable. In the next cycle it raises a one-cycle redirect pulse that carries the vector address for the winning source. A CALL strobe also copies the instruction counter into the same save register, so the most recent writer owns the return address. Software reaches the pending, mask and save registers through a small register port. Two strobes set and clear the global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, mask and save registers read as zero, the global enable is 0 and no redirect pulse is driven.
- R2: Sources other than 3, 5 and 6 are edge-sensed. A 0-to-1 change on such an input sets its pending bit (register address 0, bit n for source n) one clock later. Holding the input high does not set the bit again once it has been cleared.
- R3: Sources 3, 5 and 6 are level-sensed. Their pending bit equals the input sampled at the previous clock, and neither a software clear nor an acceptance removes it while the input stays high.
- R4: When several requests may be serviced, the lowest-numbered one is accepted.
- R5: Accepting source n drives the redirect pulse high for one cycle on the next clock, with address VecBase + n*VecStride (0x0020 + 2n by default). On the same clock the save register (address 2) takes the instruction counter and the global enable goes to 0.
- R6: A mask bit at 1 (register address 1, bit n) blocks source n, except for sources 0 and 5. A global enable of 0 blocks every source except 0, 1 and 5. Source 1 still obeys its mask bit.
- R7: Accepting an edge-sensed source clears its pending bit.
- R8: A CALL strobe copies the instruction counter into the save register and replaces any interrupt return address held there. Writes to address 2 have no effect.
- R9: Writing ones to address 0 clears those pending bits. If a new edge arrives on the same clock, its bit stays set.
- R10: The enable strobe sets the global enable and the disable strobe clears it. An acceptance on the same clock as an enable strobe leaves the global enable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low master reset |
| irqIn | input | 16 | Interrupt request lines, bit n is source n |
| icIn | input | 16 | Current instruction counter |
| callStrobe | input | 1 | CALL event: capture icIn into the save register |
| enableStrobe | input | 1 | Set the global interrupt enable |
| disableStrobe | input | 1 | Clear the global interrupt enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 pending, 1 mask, 2 save |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| intEnable | output | 1 | Current global interrupt enable |
| redirectValid | output | 1 | One-cycle pulse: load the instruction counter |
| redirectAddr | output | 16 | Vector address for the accepted source |

## Verification
The in-line assertions check several properties on every cycle:
- Edge and level capture into the pending register.
- No lower-numbered serviceable source is passed over.
- The enable is cleared after each acceptance.
- An accepted edge source has its bit cleared.
- The save register takes the instruction counter whenever it is strobed.
- Every vector address lies on the stride grid.

The bench scenarios show the remaining behaviours:
- The exemption rules for the mask and the enable, which need masked and unmasked runs with the enable both on and off.
- A clear racing a new edge on the same clock.
- A CALL overwriting an interrupt return address.
- The enable strobe losing to a simultaneous acceptance.
- The exact cycle and address of each redirect.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 16;
  localparam int SRC_W   = $clog2(NUM_SRC);

  // Control-to-datapath strobes
  typedef struct packed {
    logic             accept;   // a request is taken this cycle
    logic [SRC_W-1:0] winner;   // source number of the taken request
    logic             saveIc;   // capture instruction counter this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] MaskExempt = 16'h0021,
  parameter logic [NUM_SRC-1:0] GateExempt = 16'h0023
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               callStrobe,
  input  logic               enableStrobe,
  input  logic               disableStrobe,
  output ctrl_strobe_t       strb,
  output logic               intEnable
);

  logic [NUM_SRC-1:0] serv;
  logic [SRC_W-1:0]   winnerId;
  logic               anyServ;

  // Per-source eligibility
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign serv[g] = pend[g] & (~mask[g] | MaskExempt[g]) & (intEnable | GateExempt[g]);
  end

  // Fixed priority: lowest number wins
  always_comb begin
    winnerId = '0;
    anyServ  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (serv[i]) begin
        winnerId = SRC_W'(i);
        anyServ  = 1'b1;
      end
    end
  end

  always_comb begin
    strb.accept = anyServ;
    strb.winner = winnerId;
    strb.saveIc = anyServ | callStrobe;
  end

  // Global enable; acceptance beats the enable strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable <= 1'b0;
    end else if (anyServ || disableStrobe) begin
      intEnable <= 1'b0;
    end else if (enableStrobe) begin
      intEnable <= 1'b1;
    end
  end

  // R4
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> ((pend & (~mask | MaskExempt) & (GateExempt | {NUM_SRC{intEnable}})
                      & ((NUM_SRC'(1) << strb.winner) - NUM_SRC'(1))) == '0));

  // R5
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> !intEnable);

  // R6
  gate_respect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !intEnable) |-> GateExempt[strb.winner]);

  // R10
  disable_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    disableStrobe |=> !intEnable);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int                 IcW       = 16,
  parameter int unsigned        VecBase   = 32'h0020,
  parameter int unsigned        VecStride = 2,
  parameter logic [NUM_SRC-1:0] LevelMask = 16'h0068
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [IcW-1:0]     icIn,
  input  ctrl_strobe_t       strb,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [IcW-1:0]     regWrData,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] mask,
  output logic [IcW-1:0]     regRdData,
  output logic               redirectValid,
  output logic [IcW-1:0]     redirectAddr
);

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_SAVE = 2'd2;

  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] edgeNow;
  logic [NUM_SRC-1:0] swClr;
  logic [NUM_SRC-1:0] accClr;
  logic [IcW-1:0]     saveReg;

  assign edgeNow = irqIn & ~irqPrev;
  assign swClr   = (regWrEn && regAddr == ADDR_PEND) ? regWrData[NUM_SRC-1:0] : '0;
  assign accClr  = strb.accept ? (NUM_SRC'(1) << strb.winner) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  // Pending bits: level sources follow input, edge sources latch
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    if (LevelMask[g]) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pend[g] <= 1'b0;
        else       pend[g] <= irqIn[g];
      end
    end else begin : g_edge
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pend[g] <= 1'b0;
        else       pend[g] <= (pend[g] & ~swClr[g] & ~accClr[g]) | edgeNow[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask <= '0;
    end else if (regWrEn && regAddr == ADDR_MASK) begin
      mask <= regWrData[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveReg <= '0;
    end else if (strb.saveIc) begin
      saveReg <= icIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectAddr  <= '0;
    end else begin
      redirectValid <= strb.accept;
      if (strb.accept) begin
        redirectAddr <= IcW'(VecBase) + IcW'(strb.winner) * IcW'(VecStride);
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_PEND: regRdData[NUM_SRC-1:0] = pend;
      ADDR_MASK: regRdData[NUM_SRC-1:0] = mask;
      ADDR_SAVE: regRdData = saveReg;
      default:   regRdData = '0;
    endcase
  end

  // R2
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    |(edgeNow & ~LevelMask) |=> ((pend & $past(edgeNow & ~LevelMask)) == $past(edgeNow & ~LevelMask)));

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ##1 ((pend & LevelMask) == ($past(irqIn) & LevelMask)));

  // R7
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !LevelMask[strb.winner] && !edgeNow[strb.winner])
      |=> !pend[$past(strb.winner)]);

  // R8
  save_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveIc |=> (saveReg == $past(icIn)));

  // R5
  vector_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> ((32'(redirectAddr) - VecBase) % VecStride == 0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int                 IcW        = 16,
  parameter int unsigned        VecBase    = 32'h0020,
  parameter int unsigned        VecStride  = 2,
  parameter logic [NUM_SRC-1:0] LevelMask  = 16'h0068,
  parameter logic [NUM_SRC-1:0] MaskExempt = 16'h0021,
  parameter logic [NUM_SRC-1:0] GateExempt = 16'h0023
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [IcW-1:0]     icIn,
  input  logic               callStrobe,
  input  logic               enableStrobe,
  input  logic               disableStrobe,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [IcW-1:0]     regWrData,
  output logic [IcW-1:0]     regRdData,
  output logic               intEnable,
  output logic               redirectValid,
  output logic [IcW-1:0]     redirectAddr
);

  ctrl_strobe_t       strb;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;

  irq_ctrl #(
    .MaskExempt (MaskExempt),
    .GateExempt (GateExempt)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pend          (pend),
    .mask          (mask),
    .callStrobe    (callStrobe),
    .enableStrobe  (enableStrobe),
    .disableStrobe (disableStrobe),
    .strb          (strb),
    .intEnable     (intEnable)
  );

  irq_datapath #(
    .IcW       (IcW),
    .VecBase   (VecBase),
    .VecStride (VecStride),
    .LevelMask (LevelMask)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .irqIn         (irqIn),
    .icIn          (icIn),
    .strb          (strb),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .pend          (pend),
    .mask          (mask),
    .regRdData     (regRdData),
    .redirectValid (redirectValid),
    .redirectAddr  (redirectAddr)
  );
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] irqIn;
  logic [15:0] icIn;
  logic        callStrobe, enableStrobe, disableStrobe;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        intEnable, redirectValid;
  logic [15:0] redirectAddr;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];

  always #4 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .icIn(icIn),
    .callStrobe(callStrobe), .enableStrobe(enableStrobe), .disableStrobe(disableStrobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .intEnable(intEnable),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] vec(input int src);
    return 16'(32'h20 + src * 2);
  endfunction

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic doEnable();
    enableStrobe = 1'b1;
    tick(1);
    enableStrobe = 1'b0;
  endtask

  task automatic pulseIrq(input int src);
    irqIn[src] = 1'b1;
    tick(1);
    irqIn[src] = 1'b0;
  endtask

  // Monitor: every redirect must match the next expected vector
  always @(negedge clk) begin
    if (rstN === 1'b1 && redirectValid === 1'b1) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected redirect", {16'h0, redirectAddr}, 32'hFFFF_FFFF);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check("R5 redirect address", {16'h0, redirectAddr}, {16'h0, e});
        check("R5 enable cleared at redirect", {31'h0, intEnable}, 32'h0);
      end
    end
  end

  task automatic runTests();
    logic [15:0] d;
    // R1
    readReg(2'd0, d); check("R1 pending", d, 0);
    readReg(2'd1, d); check("R1 mask", d, 0);
    readReg(2'd2, d); check("R1 save", d, 0);
    check("R1 enable", intEnable, 0);
    check("R1 redirect", redirectValid, 0);

    // R5 basic acceptance, R2 held edge
    icIn = 16'h1234;
    doEnable();
    check("R10 enable strobe", intEnable, 1);
    expQ.push_back(vec(2));
    irqIn[2] = 1'b1;
    tick(2);
    readReg(2'd2, d); check("R5 save holds IC", d, 16'h1234);
    check("R5 enable dropped", intEnable, 0);
    tick(2);
    readReg(2'd0, d); check("R2 held input no re-set", d, 0);
    irqIn[2] = 1'b0;
    tick(1);

    // R4 priority among 2, 4, 8
    icIn = 16'h2000;
    irqIn[2] = 1'b1; irqIn[4] = 1'b1; irqIn[8] = 1'b1;
    tick(1);
    irqIn = '0;
    tick(1);
    readReg(2'd0, d); check("R2 edges latched", d, 16'h0114);
    expQ.push_back(vec(2)); doEnable(); tick(2);
    readReg(2'd0, d); check("R4 lowest first, R7 cleared", d, 16'h0110);
    expQ.push_back(vec(4)); doEnable(); tick(2);
    readReg(2'd0, d); check("R4 second winner", d, 16'h0100);
    expQ.push_back(vec(8)); doEnable(); tick(2);
    readReg(2'd0, d); check("R7 all serviced", d, 0);

    // R6 masking and gate exemptions
    writeReg(2'd1, 16'h0201);
    doEnable();
    pulseIrq(9); tick(3);
    readReg(2'd0, d); check("R6 masked source stays pending", d, 16'h0200);
    check("R6 enable untouched by masked source", intEnable, 1);
    disableStrobe = 1'b1; tick(1); disableStrobe = 1'b0;
    check("R10 disable strobe", intEnable, 0);
    expQ.push_back(vec(0)); pulseIrq(0); tick(3);
    readReg(2'd0, d); check("R6 source 0 exempt, R7 cleared", d, 16'h0200);
    expQ.push_back(vec(1)); pulseIrq(1); tick(3);
    writeReg(2'd1, 16'h0203);
    pulseIrq(1); tick(3);
    pulseIrq(11); tick(3);
    readReg(2'd0, d); check("R6 masked 1 and gated 11 held", d, 16'h0A02);
    writeReg(2'd0, 16'hFFFF);
    readReg(2'd0, d); check("R9 write-one clear", d, 0);
    writeReg(2'd1, 16'h0000);

    // R3 level source 3 (not exempt, enable 0)
    irqIn[3] = 1'b1; tick(2);
    readReg(2'd0, d); check("R3 level set", d, 16'h0008);
    writeReg(2'd0, 16'h0008); tick(1);
    readReg(2'd0, d); check("R3 level survives clear", d, 16'h0008);
    irqIn[3] = 1'b0; tick(1);
    readReg(2'd0, d); check("R3 level follows low", d, 0);

    // R3/R6 level source 5, one-cycle pulse, exempt
    icIn = 16'h3300;
    expQ.push_back(vec(5)); pulseIrq(5); tick(3);
    readReg(2'd2, d); check("R5 save on source 5", d, 16'h3300);
    readReg(2'd0, d); check("R3 source 5 dropped", d, 0);

    // R9 clear racing a new edge
    irqIn[10] = 1'b1; tick(1);
    irqIn[10] = 1'b0; tick(1);
    irqIn[10] = 1'b1;
    writeReg(2'd0, 16'h0400);
    readReg(2'd0, d); check("R9 new edge beats clear", d, 16'h0400);
    writeReg(2'd0, 16'h0400);
    readReg(2'd0, d); check("R9 clear without edge", d, 0);
    irqIn[10] = 1'b0;

    // R8 CALL overwrites interrupt return address
    icIn = 16'h7777;
    callStrobe = 1'b1; tick(1); callStrobe = 1'b0;
    readReg(2'd2, d); check("R8 CALL writes save", d, 16'h7777);
    writeReg(2'd2, 16'hAAAA);
    readReg(2'd2, d); check("R8 save not writable", d, 16'h7777);

    // R10 acceptance beats enable strobe
    doEnable();
    expQ.push_back(vec(2));
    irqIn[2] = 1'b1; tick(1);
    enableStrobe = 1'b1; tick(1); enableStrobe = 1'b0;
    check("R10 accept beats enable strobe", intEnable, 0);
    irqIn[2] = 1'b0;
    tick(4);
    check("R5 all redirects seen", expQ.size(), 0);
  endtask

  initial begin
    rstN = 1'b0; irqIn = '0; icIn = '0;
    callStrobe = 0; enableStrobe = 0; disableStrobe = 0;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    fork
      runTests();
      begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule